// File: doc/BRIEF.md
# CAN Controller Interrupt Register Group

This block holds the interrupt status, enable and clear registers of a CAN controller. Single-cycle event pulses come from the receive and transmit paths, from bus error detection, bus-off entry, arbitration loss, wake-up, sleep and a late receive filter. Each event sets a sticky status bit. Software masks these bits through the enable register and clears them by writing ones to the clear register. A single registered level output requests service whenever an enabled status bit is set.

One status bit follows a level instead of a pulse. It reports that the receive FIFO holds frames. A clear write to that bit only takes effect once the FIFO is empty, so software can drain the FIFO and clear the bit without missing a frame that arrives during the drain. Software reaches the block through a simple write port and a combinational read port, both with byte addresses.

Top module: `can_irq_regs`

## Requirements
- R1: Status sits at address 0x1C, enable at 0x20 and clear at 0x24. A read of any other address returns zero.
- R2: After reset, status and enable read zero and `irq` is low.
- R3: An event pulse sets its status bit at the next clock edge. Bit positions: 0 arbitration lost, 1 transmit done, 4 frame stored, 5 receive overflow, 6 bus error, 7 receive FIFO not empty, 9 bus-off, 10 sleep, 11 wake-up, 14 transmit FIFO empty, 17 receive filter did not finish in time.
- R4: Writing a 1 to a bit of the clear register clears that status bit. Writing a 0 leaves the bit unchanged. Several bits can be cleared in one write.
- R5: If an event and a clear of the same bit occur in the same cycle, the bit stays set.
- R6: Status bit 7 is set in every cycle where `rx_nonempty` is high, and clear writes to it are ignored during that time. Once the FIFO is empty, the bit keeps its value until a clear write removes it.
- R7: After status bit 4 has been cleared, every new frame-stored pulse sets it again.
- R8: The enable register stores only the implemented bit positions listed in R3. All other enable bits read zero.
- R9: `irq` is high exactly one cycle after some status bit and its enable bit are both set.
- R10: A read of the clear register returns zero.
- R11: A write to the status address has no effect on the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data (combinational) |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_tx_done | input | 1 | Frame transmitted pulse |
| ev_rx_stored | input | 1 | Frame stored in receive FIFO pulse |
| ev_rx_overflow | input | 1 | Receive FIFO overflow pulse |
| ev_bus_error | input | 1 | Bus error pulse |
| rx_nonempty | input | 1 | Level: receive FIFO holds frames |
| ev_bus_off | input | 1 | Bus-off entered pulse |
| ev_sleep | input | 1 | Sleep entered pulse |
| ev_wake | input | 1 | Wake-up pulse |
| ev_tx_empty | input | 1 | Transmit FIFO became empty pulse |
| ev_filter_late | input | 1 | Filter match not finished, frame dropped pulse |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions check the sticky-bit rules at every clock edge:
- an event always leaves its bit set;
- a clear without a matching event always removes the bit;
- no bit is set without an event;
- no bit changes without an event or a clear;
- the interrupt output follows the enabled status of the previous cycle.

The bench scenarios cover what those rules cannot show: the address map, masking of unimplemented bits in the enable register, the zero read of the clear register, and ignored writes to the status address. They also cover the sequences: draining the receive FIFO under a held clear request, re-arming the frame-stored bit, and the one-cycle latency of the interrupt.

// File: rtl/can_irq_regs.sv
module can_irq_regs #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] STS_ADDR = 8'h1C,
  parameter logic [AW-1:0] EN_ADDR  = 8'h20,
  parameter logic [AW-1:0] CLR_ADDR = 8'h24,
  parameter int B_ARB  = 0,
  parameter int B_TXOK = 1,
  parameter int B_RXOK = 4,
  parameter int B_OVF  = 5,
  parameter int B_ERR  = 6,
  parameter int B_RNE  = 7,
  parameter int B_BOFF = 9,
  parameter int B_SLP  = 10,
  parameter int B_WAKE = 11,
  parameter int B_TXE  = 14,
  parameter int B_FLT  = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          ev_arb_lost,
  input  logic          ev_tx_done,
  input  logic          ev_rx_stored,
  input  logic          ev_rx_overflow,
  input  logic          ev_bus_error,
  input  logic          rx_nonempty,
  input  logic          ev_bus_off,
  input  logic          ev_sleep,
  input  logic          ev_wake,
  input  logic          ev_tx_empty,
  input  logic          ev_filter_late,
  output logic          irq
);

  localparam logic [DW-1:0] ONE = DW'(1);
  localparam logic [DW-1:0] IMPL =
    (ONE << B_ARB) | (ONE << B_TXOK) | (ONE << B_RXOK) | (ONE << B_OVF) |
    (ONE << B_ERR) | (ONE << B_RNE)  | (ONE << B_BOFF) | (ONE << B_SLP) |
    (ONE << B_WAKE) | (ONE << B_TXE) | (ONE << B_FLT);

  logic [DW-1:0] sts_q, en_q, set_v, clr_v;

  // rx_nonempty is a level: while high it re-sets its bit every cycle,
  // which is what makes a clear write ineffective until the FIFO drains.
  assign set_v =
    (DW'(ev_arb_lost)    << B_ARB)  | (DW'(ev_tx_done)   << B_TXOK) |
    (DW'(ev_rx_stored)   << B_RXOK) | (DW'(ev_rx_overflow) << B_OVF) |
    (DW'(ev_bus_error)   << B_ERR)  | (DW'(rx_nonempty)  << B_RNE)  |
    (DW'(ev_bus_off)     << B_BOFF) | (DW'(ev_sleep)     << B_SLP)  |
    (DW'(ev_wake)        << B_WAKE) | (DW'(ev_tx_empty)  << B_TXE)  |
    (DW'(ev_filter_late) << B_FLT);

  assign clr_v = (wr_en && wr_addr == CLR_ADDR) ? (wr_data & IMPL) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
      irq   <= 1'b0;
    end else begin
      sts_q <= (set_v & IMPL) | (sts_q & ~clr_v);
      if (wr_en && wr_addr == EN_ADDR) en_q <= wr_data & IMPL;
      irq <= |(sts_q & en_q);
    end
  end

  always_comb begin
    case (rd_addr)
      STS_ADDR: rd_data = sts_q;
      EN_ADDR:  rd_data = en_q;
      default:  rd_data = '0;
    endcase
  end

endmodule

module can_irq_regs_chk #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] CLR_ADDR = 8'h24,
  parameter int B_RNE = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          rx_nonempty,
  input logic [DW-1:0] set_v,
  input logic [DW-1:0] sts_q,
  input logic [DW-1:0] en_q,
  input logic          irq
);

  logic [DW-1:0] clr_m;
  assign clr_m = (wr_en && wr_addr == CLR_ADDR) ? wr_data : '0;

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q & $past(set_v)) == $past(set_v)); // R3
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q & $past(clr_m) & ~$past(set_v)) == '0); // R4
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q & ~$past(sts_q) & ~$past(set_v)) == '0); // R3
  AST_UNTOUCHED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q ^ $past(sts_q)) & ~$past(set_v) & ~$past(clr_m)) == '0); // R11
  AST_RNE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_nonempty |=> sts_q[B_RNE]); // R6
  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |($past(sts_q & en_q))); // R9

endmodule

bind can_irq_regs can_irq_regs_chk #(.AW(AW), .DW(DW), .CLR_ADDR(CLR_ADDR), .B_RNE(B_RNE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rx_nonempty(rx_nonempty), .set_v(set_v), .sts_q(sts_q), .en_q(en_q), .irq(irq)
);

// File: tb/can_irq_regs_tb.sv
module can_irq_regs_tb;

  localparam logic [7:0] A_STS = 8'h1C, A_EN = 8'h20, A_CLR = 8'h24;
  localparam logic [31:0] IMPL = 32'h0002_4EF3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [31:0] ev = '0;
  logic irq;
  int total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  can_irq_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .ev_arb_lost(ev[0]), .ev_tx_done(ev[1]), .ev_rx_stored(ev[4]),
    .ev_rx_overflow(ev[5]), .ev_bus_error(ev[6]), .rx_nonempty(ev[7]),
    .ev_bus_off(ev[9]), .ev_sleep(ev[10]), .ev_wake(ev[11]),
    .ev_tx_empty(ev[14]), .ev_filter_late(ev[17]), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_check(string req, logic [7:0] a, logic [31:0] exp);
    rd_addr = a; #1;
    check(req, rd_data, exp);
  endtask

  task automatic pulse(logic [31:0] m);
    @(negedge clk); ev = m;
    @(negedge clk); ev = '0;
  endtask

  task automatic t_reset;
    rd_check("R2", A_STS, 32'h0);
    rd_check("R2", A_EN, 32'h0);
    check("R2", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_map;
    wr(A_EN, 32'hFFFF_FFFF);
    rd_check("R8", A_EN, IMPL);
    rd_check("R1", 8'h00, 32'h0);
    rd_check("R1", 8'h28, 32'h0);
    rd_check("R10", A_CLR, 32'h0);
    wr(A_EN, 32'h0);
    rd_check("R1", A_EN, 32'h0);
  endtask

  task automatic t_events;
    logic [31:0] acc = '0;
    for (int b = 0; b < 32; b++) begin
      if (IMPL[b]) begin
        pulse(32'h1 << b);
        acc[b] = 1'b1;
        rd_check("R3", A_STS, acc);
      end
    end
    wr(A_CLR, 32'hFFFF_FFFF);
    rd_check("R4", A_STS, 32'h0);
  endtask

  task automatic t_w1c;
    pulse(32'h0000_0241);
    wr(A_CLR, 32'h0000_0001);
    rd_check("R4", A_STS, 32'h0000_0240);
    wr(A_CLR, 32'h0);
    rd_check("R4", A_STS, 32'h0000_0240);
    wr(A_CLR, 32'h0000_0240);
    rd_check("R4", A_STS, 32'h0);
  endtask

  task automatic t_status_write;
    wr(A_STS, 32'hFFFF_FFFF);
    rd_check("R11", A_STS, 32'h0);
    pulse(32'h0000_0400);
    wr(A_STS, 32'h0);
    rd_check("R11", A_STS, 32'h0000_0400);
    wr(A_CLR, 32'h0000_0400);
  endtask

  task automatic t_collide;
    @(negedge clk); ev = 32'h0002_0000; wr_en = 1'b1; wr_addr = A_CLR; wr_data = 32'h0002_0000;
    @(negedge clk); ev = '0; wr_en = 1'b0;
    rd_check("R5", A_STS, 32'h0002_0000);
    wr(A_CLR, 32'h0002_0000);
    rd_check("R5", A_STS, 32'h0);
  endtask

  task automatic t_rne;
    @(negedge clk); ev[7] = 1'b1;
    @(negedge clk);
    rd_check("R6", A_STS, 32'h0000_0080);
    wr(A_CLR, 32'h0000_0080);
    rd_check("R6", A_STS, 32'h0000_0080);
    ev[7] = 1'b0;
    @(negedge clk);
    rd_check("R6", A_STS, 32'h0000_0080);
    wr(A_CLR, 32'h0000_0080);
    rd_check("R6", A_STS, 32'h0);
  endtask

  task automatic t_rxok;
    pulse(32'h0000_0010);
    wr(A_CLR, 32'h0000_0010);
    rd_check("R7", A_STS, 32'h0);
    pulse(32'h0000_0010);
    rd_check("R7", A_STS, 32'h0000_0010);
    wr(A_CLR, 32'h0000_0010);
    pulse(32'h0000_0010);
    rd_check("R7", A_STS, 32'h0000_0010);
    wr(A_CLR, 32'h0000_0010);
  endtask

  task automatic t_irq;
    wr(A_EN, 32'h0000_0040);
    pulse(32'h0000_0200);
    @(negedge clk);
    check("R9", {31'b0, irq}, 32'h0);
    pulse(32'h0000_0040);
    check("R9", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R9", {31'b0, irq}, 32'h1);
    wr(A_CLR, 32'h0000_0040);
    check("R9", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R9", {31'b0, irq}, 32'h0);
    wr(A_CLR, 32'hFFFF_FFFF);
    wr(A_EN, 32'h0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected<20000 cycles", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_events();
    t_w1c();
    t_status_write();
    t_collide();
    t_rne();
    t_rxok();
    t_irq();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule